// File: doc/BRIEF.md
# Process Context Switch Sequencer

This block moves a processor between processes entirely in hardware. It holds the live register set of the running process: program counter, code base, global-data base, data-frame-table base, local-frame base, free-top pointer and stack limit. It also holds the address of the running process's descriptor, which sits at the base of that process's procedure stack. When a switch is requested, the block first stores every live register into the running descriptor. It then fills the register set from the target descriptor and makes the target the running process. The memory side is a word-wide request/acknowledge port.

Interrupts are not vectored to handler code. Each one is a full process switch whose target descriptor address is read from a table at the bottom of memory, indexed by interrupt number. One interrupt line is driven inside the block by the stack guard. It fires whenever the free-top pointer reaches the stack limit, so an overflowing process is switched out just like one that takes any other interrupt. The execution unit issues switch instructions through a request input and moves the free-top pointer through a write port.

Top module: `proc_switch_seq`

## Requirements
- R1: After synchronous reset, busy_o, done_o, mem_req_o and irq_grant_o are 0. cur_desc_o equals RESET_DESC, stack_limit_o is all ones, and every other register output is 0.
- R2: A switch writes the seven registers to cur_desc_o+k for k = 0..6, in the order program counter (k=0), code base (1), global base (2), data-frame-table base (3), local-frame base (4), free-top pointer (5), stack limit (6). It then reads target+k for k = 0..6 in the same order. No other transfer is made.
- R3: Each word read from target+k appears on register output k. In the cycle after the last read is acknowledged, done_o is high for exactly one cycle, busy_o is low, and cur_desc_o equals the target. When the target overlaps the running descriptor, the reads return the words just written.
- R4: An interrupt n first reads the word at address VEC_BASE+n (VEC_BASE is 0) and uses that word as the target descriptor address for the save/restore of R2.
- R5: In an idle cycle, the lowest-numbered pending interrupt is accepted, and irq_grant_o shows that single bit in the acceptance cycle. A switch request (sw_req_i high) is accepted only when no interrupt is pending. A switch request that coincides with an interrupt is not taken.
- R6: While busy_o is high, irq_grant_o stays 0 and no new request is accepted. An interrupt still pending when done_o pulses is granted in that cycle.
- R7: Interrupt number OVF_IRQ (0) is pending whenever the free-top pointer is greater than or equal to the stack limit, equality included. A free-top one below the limit raises nothing.
- R8: A free-top write (sft_wr_en_i) in a cycle with busy_o low updates free_top_o at the next edge. A write while busy_o is high is ignored.
- R9: A transfer holds mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o steady until the edge at which mem_ack_i is high, for any number of wait cycles.
- R10: busy_o rises in the cycle after acceptance and stays high until the done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 1 | Switch instruction request |
| sw_target_i | input | AW | Target descriptor address for a switch |
| irq_i | input | NIRQ | Interrupt request lines, level |
| sft_wr_en_i | input | 1 | Free-top pointer write enable |
| sft_wr_data_i | input | DW | New free-top pointer value |
| busy_o | output | 1 | Save/restore sequence in progress |
| done_o | output | 1 | One-cycle pulse after last register loaded |
| irq_grant_o | output | NIRQ | One-hot interrupt accepted this cycle |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Transfer completes at this edge |
| mem_rdata_i | input | DW | Read data, valid with ack |
| pc_o | output | DW | Program counter |
| code_base_o | output | DW | Code segment base |
| glob_base_o | output | DW | Global data base |
| dft_base_o | output | DW | Data-frame-table base |
| local_base_o | output | DW | Local frame base |
| free_top_o | output | DW | Procedure-stack free-top pointer |
| stack_limit_o | output | DW | Procedure-stack limit |
| cur_desc_o | output | AW | Running process descriptor address |

## Verification
The bench switches to a target equal to the running descriptor. A design that reads before it writes, or that loads from stale memory, would come back with the old contents instead of its own saved registers. Free-top values one below and exactly at the limit separate a strict compare from the required inclusive one. Simultaneous interrupts and a switch request show whether priority is lowest-number-first and whether the switch is dropped. Interrupts and free-top writes held through a busy sequence catch a design that restarts mid-switch or lets a write corrupt the freshly loaded pointer. Memory latency is swept from zero to several wait cycles to catch a transfer that advances without its acknowledge.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int NREG = 7;
    localparam int IXW  = 3;

    // Register slot numbers double as descriptor word offsets
    typedef enum logic [IXW-1:0] {
        RG_PC    = 3'd0,
        RG_CODE  = 3'd1,
        RG_GLOB  = 3'd2,
        RG_DFT   = 3'd3,
        RG_LOCAL = 3'd4,
        RG_FREE  = 3'd5,
        RG_LIMIT = 3'd6
    } reg_slot_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_SAVE = 2'd2,
        ST_LOAD = 2'd3
    } seq_state_e;

    function automatic logic is_last_slot(input logic [IXW-1:0] s);
        return s == IXW'(NREG - 1);
    endfunction

endpackage

// File: rtl/psw_stack_guard.sv
module psw_stack_guard #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] free_top,
    input  logic [DW-1:0] limit,
    output logic          overflow
);
    always_comb begin
        overflow = (free_top >= limit);
    end
endmodule

// File: rtl/psw_irq_arbiter.sv
module psw_irq_arbiter #(
    parameter int NIRQ = 4,
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic [NIRQ-1:0] req,
    output logic            any,
    output logic [IW-1:0]   win,
    output logic [NIRQ-1:0] grant
);
    always_comb begin
        any   = |req;
        win   = '0;
        grant = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = IW'(i);
            end
        end
        if (enable && any) begin
            grant = NIRQ'(1) << win;
        end
    end

    // R5: at most one line granted, and never one above a lower pending line
    assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_grant_lowest_R5: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((req & (grant - NIRQ'(1))) == '0));
endmodule

// File: rtl/psw_ctx_file.sv
module psw_ctx_file
    import psw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en,
    input  logic [IXW-1:0]           ld_slot,
    input  logic [DW-1:0]            ld_data,
    input  logic                     free_wr_en,
    input  logic [DW-1:0]            free_wr_data,
    output logic [NREG-1:0][DW-1:0]  q
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [DW-1:0] RST_VAL = (g == int'(RG_LIMIT)) ? '1 : '0;
        if (g == int'(RG_FREE)) begin : g_free
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[g] <= RST_VAL;
                end else if (ld_en && ld_slot == IXW'(g)) begin
                    q[g] <= ld_data;
                end else if (free_wr_en) begin
                    q[g] <= free_wr_data;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    q[g] <= RST_VAL;
                end else if (ld_en && ld_slot == IXW'(g)) begin
                    q[g] <= ld_data;
                end
            end
        end
    end

    // R3: registers only change through a load or the free-top port
    assert_ctx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !free_wr_en) |=> $stable(q));
endmodule

// File: rtl/proc_switch_seq.sv
module proc_switch_seq
    import psw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32,
    parameter int NIRQ = 4,
    parameter int OVF_IRQ = 0,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter logic [AW-1:0] RESET_DESC = AW'(32'h100)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_req_i,
    input  logic [AW-1:0]   sw_target_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            sft_wr_en_i,
    input  logic [DW-1:0]   sft_wr_data_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [NIRQ-1:0] irq_grant_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic            mem_ack_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [DW-1:0]   pc_o,
    output logic [DW-1:0]   code_base_o,
    output logic [DW-1:0]   glob_base_o,
    output logic [DW-1:0]   dft_base_o,
    output logic [DW-1:0]   local_base_o,
    output logic [DW-1:0]   free_top_o,
    output logic [DW-1:0]   stack_limit_o,
    output logic [AW-1:0]   cur_desc_o
);
    localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    seq_state_e               state;
    logic [IXW-1:0]           slot;
    logic [AW-1:0]            cur_desc;
    logic [AW-1:0]            target;
    logic [AW-1:0]            vec_addr;
    logic                     done_q;
    logic [NREG-1:0][DW-1:0]  ctx;
    logic                     ovf;
    logic [NIRQ-1:0]          pending;
    logic [NIRQ-1:0]          grant;
    logic                     any_irq;
    logic [IW-1:0]            win;
    logic                     idle;
    logic                     load_fire;
    logic [AW-1:0]            rd_word_addr;

    assign idle      = (state == ST_IDLE);
    assign load_fire = (state == ST_LOAD) && mem_ack_i;
    assign pending   = irq_i | (NIRQ'(ovf) << OVF_IRQ);

    psw_stack_guard #(.DW(DW)) guard_i (
        .free_top (ctx[RG_FREE]),
        .limit    (ctx[RG_LIMIT]),
        .overflow (ovf)
    );

    psw_irq_arbiter #(.NIRQ(NIRQ)) arb_i (
        .clk    (clk),
        .rst    (rst),
        .enable (idle),
        .req    (pending),
        .any    (any_irq),
        .win    (win),
        .grant  (grant)
    );

    psw_ctx_file #(.DW(DW)) ctx_i (
        .clk          (clk),
        .rst          (rst),
        .ld_en        (load_fire),
        .ld_slot      (slot),
        .ld_data      (mem_rdata_i),
        .free_wr_en   (sft_wr_en_i && idle),
        .free_wr_data (sft_wr_data_i),
        .q            (ctx)
    );

    assign rd_word_addr = mem_rdata_i[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            slot     <= '0;
            cur_desc <= RESET_DESC;
            target   <= '0;
            vec_addr <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    slot <= '0;
                    if (any_irq) begin
                        vec_addr <= VEC_BASE + AW'(win);
                        state    <= ST_VEC;
                    end else if (sw_req_i) begin
                        target <= sw_target_i;
                        state  <= ST_SAVE;
                    end
                end
                ST_VEC: begin
                    if (mem_ack_i) begin
                        target <= rd_word_addr;
                        state  <= ST_SAVE;
                    end
                end
                ST_SAVE: begin
                    if (mem_ack_i) begin
                        if (is_last_slot(slot)) begin
                            slot  <= '0;
                            state <= ST_LOAD;
                        end else begin
                            slot <= slot + IXW'(1);
                        end
                    end
                end
                ST_LOAD: begin
                    if (mem_ack_i) begin
                        if (is_last_slot(slot)) begin
                            slot     <= '0;
                            state    <= ST_IDLE;
                            cur_desc <= target;
                            done_q   <= 1'b1;
                        end else begin
                            slot <= slot + IXW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = !idle;
        mem_we_o    = (state == ST_SAVE);
        mem_wdata_o = '0;
        mem_addr_o  = '0;
        case (state)
            ST_VEC:  mem_addr_o = vec_addr;
            ST_SAVE: begin
                mem_addr_o  = cur_desc + AW'(slot);
                mem_wdata_o = ctx[slot];
            end
            ST_LOAD: mem_addr_o = target + AW'(slot);
            default: mem_addr_o = '0;
        endcase
    end

    assign busy_o        = !idle;
    assign done_o        = done_q;
    assign irq_grant_o   = grant;
    assign cur_desc_o    = cur_desc;
    assign pc_o          = ctx[RG_PC];
    assign code_base_o   = ctx[RG_CODE];
    assign glob_base_o   = ctx[RG_GLOB];
    assign dft_base_o    = ctx[RG_DFT];
    assign local_base_o  = ctx[RG_LOCAL];
    assign free_top_o    = ctx[RG_FREE];
    assign stack_limit_o = ctx[RG_LIMIT];

    // R9: an unacknowledged transfer is held unchanged
    assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));
    // R6: nothing is granted during a sequence
    assert_no_grant_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (irq_grant_o == '0));
    // R3: done is a single pulse that ends a sequence
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));
    // R7: an idle overflow is always taken
    assert_overflow_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (free_top_o >= stack_limit_o)) |-> (irq_grant_o != '0));
    // R8: free-top moves during a sequence only through a descriptor load
    assert_free_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(mem_ack_i && !mem_we_o)) |=> $stable(free_top_o));
endmodule

// File: tb/proc_switch_seq_tb.sv
module proc_switch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_req = 1'b0;
    logic [31:0] sw_target = '0;
    logic [3:0]  irq = '0;
    logic        sft_wr_en = 1'b0;
    logic [31:0] sft_wr_data = '0;
    logic        busy, done, mem_req, mem_we, mem_ack;
    logic [3:0]  grant;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [31:0] pc, code_b, glob_b, dft_b, local_b, free_top, limit, cur_desc;

    always #4 clk = ~clk;

    proc_switch_seq dut_i (
        .clk(clk), .rst(rst), .sw_req_i(sw_req), .sw_target_i(sw_target),
        .irq_i(irq), .sft_wr_en_i(sft_wr_en), .sft_wr_data_i(sft_wr_data),
        .busy_o(busy), .done_o(done), .irq_grant_o(grant),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .pc_o(pc), .code_base_o(code_b), .glob_base_o(glob_b), .dft_base_o(dft_b),
        .local_base_o(local_b), .free_top_o(free_top), .stack_limit_o(limit),
        .cur_desc_o(cur_desc)
    );

    // memory model with programmable wait cycles
    logic [31:0] mem [0:511];
    logic [31:0] log_addr [0:1023];
    logic [31:0] log_data [0:1023];
    logic        log_we   [0:1023];
    int          log_n = 0;
    int          xfer_no = 0;
    int          wcnt = 0;
    int          lat_mode = 0;

    function automatic logic [31:0] init_word(input int a);
        case (a)
            0: return 32'h0000_00C0;
            1: return 32'h0000_0040;
            2: return 32'h0000_0060;
            3: return 32'h0000_0080;
            default: return (32'(a) << 12) | 32'h3C5;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int a = 0; a < 512; a++) mem[a] <= init_word(a);
            mem_ack <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt == 0) begin
                mem_ack <= 1'b1;
                mem_rdata <= mem[mem_addr[8:0]];
                if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
                log_addr[log_n] <= mem_addr;
                log_we[log_n] <= mem_we;
                log_data[log_n] <= mem_we ? mem_wdata : mem[mem_addr[8:0]];
                log_n <= log_n + 1;
                xfer_no <= xfer_no + 1;
                wcnt <= (lat_mode == 0) ? 0 : (xfer_no % (lat_mode + 1));
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] exp_r [0:6];
    logic [31:0] exp_ld [0:6];
    logic [31:0] exp_cur;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] out_reg(input int k);
        case (k)
            0: return pc;
            1: return code_b;
            2: return glob_b;
            3: return dft_b;
            4: return local_b;
            5: return free_top;
            default: return limit;
        endcase
    endfunction

    task automatic predict(input logic [31:0] tgt);
        for (int k = 0; k < 7; k++) begin
            logic [31:0] w;
            w = mem[(tgt + 32'(k)) & 32'h1FF];
            for (int j = 0; j < 7; j++)
                if (exp_cur + 32'(j) == tgt + 32'(k)) w = exp_r[j];
            exp_ld[k] = w;
        end
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R3 done pulse seen", 32'(done), 1);
        chk(busy == 1'b0, "R10 busy low with done", 32'(busy), 0);
    endtask

    task automatic check_seq(input int base, input logic [31:0] tgt, input bit vec, input logic [31:0] vaddr);
        int off;
        off = vec ? 1 : 0;
        chk(log_n - base == 14 + off, "R2 transfer count", 32'(log_n - base), 32'(14 + off));
        if (vec)
            chk(!log_we[base] && log_addr[base] == vaddr, "R4 vector read address", log_addr[base], vaddr);
        for (int k = 0; k < 7; k++) begin
            chk(log_we[base+off+k] && log_addr[base+off+k] == exp_cur + 32'(k),
                "R2 save address", log_addr[base+off+k], exp_cur + 32'(k));
            chk(log_data[base+off+k] == exp_r[k], "R2 save data", log_data[base+off+k], exp_r[k]);
            chk(!log_we[base+off+7+k] && log_addr[base+off+7+k] == tgt + 32'(k),
                "R2 load address", log_addr[base+off+7+k], tgt + 32'(k));
        end
        for (int k = 0; k < 7; k++)
            chk(out_reg(k) == exp_ld[k], "R3 loaded register", out_reg(k), exp_ld[k]);
        chk(cur_desc == tgt, "R3 running descriptor", cur_desc, tgt);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", 32'(done), 0);
        for (int k = 0; k < 7; k++) exp_r[k] = exp_ld[k];
        exp_cur = tgt;
    endtask

    task automatic do_switch(input logic [31:0] tgt);
        int base;
        predict(tgt);
        base = log_n;
        sw_req = 1'b1;
        sw_target = tgt;
        @(negedge clk);
        sw_req = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 1);
        wait_done();
        check_seq(base, tgt, 1'b0, 0);
    endtask

    task automatic do_irq(input int n);
        int base;
        logic [31:0] tgt;
        tgt = mem[n];
        predict(tgt);
        base = log_n;
        irq = 4'(1 << n);
        #2;
        chk(grant == 4'(1 << n), "R5 single grant", 32'(grant), 32'(1 << n));
        @(negedge clk);
        irq = '0;
        wait_done();
        check_seq(base, tgt, 1'b1, 32'(n));
    endtask

    task automatic sft_write(input logic [31:0] v);
        sft_wr_en = 1'b1;
        sft_wr_data = v;
        @(negedge clk);
        sft_wr_en = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req, "R1 idle after reset", {busy, done, mem_req}, 0);
        chk(grant == '0, "R1 no grant", 32'(grant), 0);
        chk(cur_desc == 32'h100, "R1 reset descriptor", cur_desc, 32'h100);
        chk(limit == 32'hFFFF_FFFF, "R1 reset limit", limit, 32'hFFFF_FFFF);
        for (int k = 0; k < 6; k++) chk(out_reg(k) == 0, "R1 reset register", out_reg(k), 0);
        for (int k = 0; k < 6; k++) exp_r[k] = 0;
        exp_r[6] = 32'hFFFF_FFFF;
        exp_cur = 32'h100;

        // R2 R3 R9 sweep over targets and memory latency, including self-switch
        for (int lat = 0; lat < 4; lat++) begin
            lat_mode = lat;
            do_switch(32'h40);
            do_switch(32'h60);
            do_switch(32'h60);
            do_switch(32'h63);
            do_switch(32'hA0);
        end
        lat_mode = 1;

        // R4 R5 each external interrupt
        for (int n = 1; n < 4; n++) do_irq(n);

        // R5 priority, and switch request dropped when an interrupt coincides
        begin
            int base;
            logic [31:0] tgt;
            tgt = mem[2];
            predict(tgt);
            base = log_n;
            sw_req = 1'b1;
            sw_target = 32'h80;
            irq = 4'b1100;
            #2;
            chk(grant == 4'b0100, "R5 lowest number wins", 32'(grant), 32'h4);
            @(negedge clk);
            sw_req = 1'b0;
            irq = '0;
            wait_done();
            check_seq(base, tgt, 1'b1, 32'd2);
            chk(busy == 1'b0, "R5 coincident switch not taken", 32'(busy), 0);
        end

        // R6 R8 requests and writes during a sequence
        begin
            int base;
            int t;
            predict(32'h40);
            base = log_n;
            sw_req = 1'b1;
            sw_target = 32'h40;
            @(negedge clk);
            sw_req = 1'b0;
            irq = 4'b0010;
            sft_wr_en = 1'b1;
            sft_wr_data = 32'hDEAD_0000;
            t = 0;
            while (!done && t < 300) begin
                chk(grant == '0, "R6 no grant while busy", 32'(grant), 0);
                @(negedge clk);
                t++;
            end
            sft_wr_en = 1'b0;
            chk(free_top == exp_ld[5], "R8 write while busy ignored", free_top, exp_ld[5]);
            chk(grant == 4'b0010, "R6 held interrupt granted at done", 32'(grant), 32'h2);
            chk(done == 1'b1, "R3 done pulse seen", 32'(done), 1);
            check_seq(base, 32'h40, 1'b0, 0);
            // the interrupt was accepted at the edge after done
            predict(mem[1]);
            base = log_n - 0;
            irq = '0;
            wait_done();
            check_seq(base, mem[1], 1'b1, 32'd1);
        end

        // R8 idle write, R7 overflow at limit-1 and at limit
        sft_write(32'h1234);
        chk(free_top == 32'h1234, "R8 idle write applied", free_top, 32'h1234);
        exp_r[5] = 32'h1234;
        sft_write(exp_r[6] - 1);
        exp_r[5] = exp_r[6] - 1;
        for (int i = 0; i < 3; i++) begin
            chk(grant == '0 && !busy, "R7 no overflow below limit", 32'(grant), 0);
            @(negedge clk);
        end
        begin
            int base;
            logic [31:0] tgt;
            tgt = mem[0];
            sft_wr_en = 1'b1;
            sft_wr_data = exp_r[6];
            @(negedge clk);
            sft_wr_en = 1'b0;
            exp_r[5] = exp_r[6];
            predict(tgt);
            base = log_n;
            chk(grant == 4'b0001, "R7 overflow at limit", 32'(grant), 32'h1);
            wait_done();
            check_seq(base, tgt, 1'b1, 32'd0);
            chk(grant == '0, "R7 overflow cleared by new context", 32'(grant), 0);
        end

        summary();
    end
endmodule